// File: doc/BRIEF.md
# Translation Entry Table with Shift-In Replacement

This block stores the entries of a small fully associative address translation table. Each entry holds a virtual page-pair tag, an address-space identifier, a global flag, and two halves, even and odd. Each half carries a valid flag, a dirty flag and a physical frame number. The table is exposed combinationally to the translator as one flat bus. An indexed read port returns a single entry.

Two write commands change the table. An indexed write replaces one addressed entry. A random write places a new entry above the protected low region, whose size is set by the `wired_cnt` input. With `place_shift` high, the block inserts rather than overwrites. Every unprotected entry moves one slot toward the top in a single clock, the entry in the top slot is dropped, and the new entry lands in the lowest unprotected slot. Recently written entries therefore gather near the bottom of the table. With `place_shift` low, the conventional placement is used: the slot is chosen from a free-running counter modulo the number of unprotected slots.

Any write command raises a one-cycle pulse that tells the translator to drop its cached translations.

Top module: `tlb_entry_store`

## Requirements
- R1: After reset, every entry reads as all zeros and `inval_pulse` is low.
- R2: An indexed write (`cmd_write` high, `cmd_random` low) stores the new entry at `cmd_index`, visible one clock later, and leaves every other entry unchanged.
- R3: In shift placement with `wired_cnt` = W below 16, one random write does three things in a single clock. Each old entry at index W..14 appears at its index plus one. The old entry at index 15 is discarded. The new entry appears at index W. Tag, identifier, flags and both frame halves move as one unit.
- R4: A random write, in either placement, never changes an entry whose index is below `wired_cnt`.
- R5: In counter placement with W below 16, a random write stores the new entry at index W + (c mod (16 − W)) and changes no other entry. Here c is the 8-bit counter value, which equals the number of rising clock edges since reset release, wrapping at 256.
- R6: A random write with `wired_cnt` of 16 or more changes no entry, in either placement.
- R7: `inval_pulse` is high for exactly the clock after each clock in which `cmd_write` or `cmd_random` was sampled high. Otherwise it is low.
- R8: When `cmd_write` and `cmd_random` are both high, the random write is performed and the indexed write is ignored.
- R9: Read ports are combinational. `rd_entry` follows `rd_index` within the same cycle. Entry i occupies bits [i*72 +: 72] of `table_flat`. Inside an entry, from MSB to LSB, the fields are: tag (19), identifier (8), global (1), even valid (1), even dirty (1), even frame (20), odd valid (1), odd dirty (1), odd frame (20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_write | input | 1 | Indexed write command |
| cmd_index | input | 4 | Target slot of indexed write |
| cmd_random | input | 1 | Random write command |
| place_shift | input | 1 | 1: shift-in placement, 0: counter placement |
| wired_cnt | input | 5 | Number of protected low slots |
| new_vpn2 | input | 19 | New entry page-pair tag |
| new_asid | input | 8 | New entry address-space identifier |
| new_glob | input | 1 | New entry global flag |
| new_v0 | input | 1 | Even half valid |
| new_d0 | input | 1 | Even half dirty |
| new_pfn0 | input | 20 | Even half frame number |
| new_v1 | input | 1 | Odd half valid |
| new_d1 | input | 1 | Odd half dirty |
| new_pfn1 | input | 20 | Odd half frame number |
| rd_index | input | 4 | Indexed read select |
| rd_entry | output | 72 | Selected entry |
| table_flat | output | 1152 | All entries, entry i at [i*72 +: 72] |
| inval_pulse | output | 1 | Translation cache invalidate pulse |

## Verification
The bench writes a distinct random pattern into every slot. Because of this, a shifted entry that is misrouted, an entry moved only in part, or an off-by-one in the insert slot each shows up as a mismatch in a specific slot. Shift placement is run with the protected region empty, with a middle size, and with one free slot. These three runs separate the no-move and the full-move cases from the general band. Counter placement is run at several counter values and protection sizes, so that modulo and offset errors show up. Protection sizes of 16 and above, and simultaneous write commands, are each checked against an unchanged table.

// File: rtl/tlb_store_pkg.sv
`timescale 1ns/1ps
package tlb_store_pkg;

  // Slot chosen by the counter placement: protected base plus counter
  // folded into the number of unprotected slots.
  function automatic int trad_slot(input int wired, input int ctr, input int entries);
    int span;
    span = entries - wired;
    if (span <= 0) return 0;
    return wired + (ctr % span);
  endfunction

  // True when slot idx receives its lower neighbour on a shift insert.
  function automatic bit in_shift_band(input int idx, input int wired);
    return idx > wired;
  endfunction

  // True when a protected-region size leaves at least one free slot.
  function automatic bit wired_leaves_room(input int wired, input int entries);
    return wired < entries;
  endfunction

endpackage

// File: rtl/tlb_rand_ctr.sv
`timescale 1ns/1ps
module tlb_rand_ctr #(
  parameter int CTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CTR_W-1:0] ctr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr <= '0;
    else        ctr <= ctr + 1'b1;
  end
endmodule

// File: rtl/tlb_place_ctl.sv
`timescale 1ns/1ps
module tlb_place_ctl
  import tlb_store_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTR_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               cmd_write,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic               cmd_random,
  input  logic               place_shift,
  input  logic [IDX_W:0]     wired_cnt,
  input  logic [CTR_W-1:0]   ctr,
  output logic [ENTRIES-1:0] sel_new,
  output logic [ENTRIES-1:0] sel_below,
  output logic               evt_trad,
  output logic               evt_noop,
  output logic [IDX_W-1:0]   tgt_slot
);
  logic room;
  assign room = wired_leaves_room(int'(wired_cnt), ENTRIES);

  always_comb begin
    sel_new   = '0;
    sel_below = '0;
    evt_trad  = 1'b0;
    evt_noop  = 1'b0;
    tgt_slot  = '0;
    if (cmd_random) begin
      if (!room) begin
        evt_noop = 1'b1;
      end else if (place_shift) begin
        tgt_slot = wired_cnt[IDX_W-1:0];
        for (int i = 0; i < ENTRIES; i++) begin
          if (i == int'(wired_cnt))                  sel_new[i]   = 1'b1;
          else if (in_shift_band(i, int'(wired_cnt))) sel_below[i] = 1'b1;
        end
      end else begin
        evt_trad = 1'b1;
        tgt_slot = IDX_W'(trad_slot(int'(wired_cnt), int'(ctr), ENTRIES));
        sel_new[tgt_slot] = 1'b1;
      end
    end else if (cmd_write) begin
      tgt_slot = cmd_index;
      sel_new[cmd_index] = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_slot.sv
`timescale 1ns/1ps
module tlb_slot #(
  parameter int ENT_W = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_new,
  input  logic             take_below,
  input  logic [ENT_W-1:0] new_ent,
  input  logic [ENT_W-1:0] below_ent,
  output logic [ENT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (take_new)   q <= new_ent;
    else if (take_below) q <= below_ent;
  end
endmodule

// File: rtl/tlb_entry_store.sv
`timescale 1ns/1ps
module tlb_entry_store #(
  parameter int ENTRIES = 16,
  parameter int VPN2_W  = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int CTR_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int HALF_W = PFN_W + 2,
  localparam int ENT_W  = VPN2_W + ASID_W + 1 + 2 * HALF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_write,
  input  logic [IDX_W-1:0]         cmd_index,
  input  logic                     cmd_random,
  input  logic                     place_shift,
  input  logic [IDX_W:0]           wired_cnt,
  input  logic [VPN2_W-1:0]        new_vpn2,
  input  logic [ASID_W-1:0]        new_asid,
  input  logic                     new_glob,
  input  logic                     new_v0,
  input  logic                     new_d0,
  input  logic [PFN_W-1:0]         new_pfn0,
  input  logic                     new_v1,
  input  logic                     new_d1,
  input  logic [PFN_W-1:0]         new_pfn1,
  input  logic [IDX_W-1:0]         rd_index,
  output logic [ENT_W-1:0]         rd_entry,
  output logic [ENTRIES*ENT_W-1:0] table_flat,
  output logic                     inval_pulse
);
  logic [ENT_W-1:0]   new_flat;
  logic [ENT_W-1:0]   slot_q [ENTRIES];
  logic [CTR_W-1:0]   ctr;
  logic [ENTRIES-1:0] sel_new, sel_below;
  logic               evt_trad, evt_noop;
  logic [IDX_W-1:0]   tgt_slot;
  logic               any_cmd;

  assign new_flat = {new_vpn2, new_asid, new_glob,
                     new_v0, new_d0, new_pfn0,
                     new_v1, new_d1, new_pfn1};

  tlb_rand_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ctr(ctr)
  );

  tlb_place_ctl #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) u_ctl (
    .cmd_write(cmd_write), .cmd_index(cmd_index), .cmd_random(cmd_random),
    .place_shift(place_shift), .wired_cnt(wired_cnt), .ctr(ctr),
    .sel_new(sel_new), .sel_below(sel_below),
    .evt_trad(evt_trad), .evt_noop(evt_noop), .tgt_slot(tgt_slot)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic [ENT_W-1:0] below;
    if (i == 0) begin : g_base
      assign below = '0;
    end else begin : g_up
      assign below = slot_q[i-1];
    end
    tlb_slot #(.ENT_W(ENT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .take_new(sel_new[i]), .take_below(sel_below[i]),
      .new_ent(new_flat), .below_ent(below), .q(slot_q[i])
    );
    assign table_flat[i*ENT_W +: ENT_W] = slot_q[i];
  end

  assign rd_entry = slot_q[rd_index];

  assign any_cmd = cmd_write | cmd_random;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inval_pulse <= 1'b0;
    else        inval_pulse <= any_cmd;
  end
endmodule

// File: rtl/tlb_store_chk.sv
`timescale 1ns/1ps
module tlb_store_chk #(
  parameter int ENTRIES = 16,
  parameter int ENT_W   = 72,
  parameter int IDX_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_write,
  input logic                     cmd_random,
  input logic                     place_shift,
  input logic [IDX_W:0]           wired_cnt,
  input logic [IDX_W-1:0]         cmd_index,
  input logic [ENT_W-1:0]         new_flat,
  input logic [ENTRIES*ENT_W-1:0] table_flat,
  input logic                     inval_pulse,
  input logic                     evt_trad,
  input logic                     evt_noop,
  input logic [IDX_W-1:0]         tgt_slot
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    // R4: protected slots survive a random write
    a_r4_wired_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_random && int'(wired_cnt) > i) |=> $stable(table_flat[i*ENT_W +: ENT_W]));
    // R3: inserted entry lands at the protected boundary
    a_r3_insert: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_random && place_shift && int'(wired_cnt) == i)
        |=> table_flat[i*ENT_W +: ENT_W] == $past(new_flat));
    // R2: indexed write touches only its slot
    a_r2_only_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_write && !cmd_random && int'(cmd_index) != i)
        |=> $stable(table_flat[i*ENT_W +: ENT_W]));
    // R6: oversized protection leaves the table alone
    a_r6_noop: assert property (@(posedge clk) disable iff (!rst_n)
      evt_noop |=> $stable(table_flat[i*ENT_W +: ENT_W]));
    if (i > 0) begin : g_up
      // R3: band entries move one slot toward the top
      a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_random && place_shift && int'(wired_cnt) < i)
          |=> table_flat[i*ENT_W +: ENT_W] == $past(table_flat[(i-1)*ENT_W +: ENT_W]));
    end
  end

  // R7: invalidate pulse follows each command by one clock
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write || cmd_random) |=> inval_pulse);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_write || cmd_random) |=> !inval_pulse);
  // R5: counter placement stays inside the unprotected region
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trad |-> ({1'b0, tgt_slot} >= wired_cnt));
endmodule

bind tlb_entry_store tlb_store_chk #(
  .ENTRIES(ENTRIES), .ENT_W(ENT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_write(cmd_write), .cmd_random(cmd_random),
  .place_shift(place_shift), .wired_cnt(wired_cnt), .cmd_index(cmd_index),
  .new_flat(new_flat), .table_flat(table_flat), .inval_pulse(inval_pulse),
  .evt_trad(evt_trad), .evt_noop(evt_noop), .tgt_slot(tgt_slot)
);

// File: tb/tlb_entry_store_bench.sv
`timescale 1ns/1ps
module tlb_entry_store_bench;
  localparam int N  = 16;
  localparam int EW = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_write = 1'b0, cmd_random = 1'b0, place_shift = 1'b1;
  logic [3:0] cmd_index = '0, rd_index = '0;
  logic [4:0] wired_cnt = '0;
  logic [18:0] new_vpn2 = '0;
  logic [7:0]  new_asid = '0;
  logic new_glob = 0, new_v0 = 0, new_d0 = 0, new_v1 = 0, new_d1 = 0;
  logic [19:0] new_pfn0 = '0, new_pfn1 = '0;
  logic [EW-1:0]   rd_entry;
  logic [N*EW-1:0] table_flat;
  logic inval_pulse;

  tlb_entry_store u_tlb_entry_store (
    .clk(clk), .rst_n(rst_n), .cmd_write(cmd_write), .cmd_index(cmd_index),
    .cmd_random(cmd_random), .place_shift(place_shift), .wired_cnt(wired_cnt),
    .new_vpn2(new_vpn2), .new_asid(new_asid), .new_glob(new_glob),
    .new_v0(new_v0), .new_d0(new_d0), .new_pfn0(new_pfn0),
    .new_v1(new_v1), .new_d1(new_d1), .new_pfn1(new_pfn1),
    .rd_index(rd_index), .rd_entry(rd_entry), .table_flat(table_flat),
    .inval_pulse(inval_pulse)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          kind;   // 0 table slot, 1 invalidate, 2 read port
    int          idx;
    logic [EW-1:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  logic [EW-1:0] mdl [N];
  logic [7:0] bctr = '0;
  int total = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n) bctr <= bctr + 8'd1;

  // Monitor: pops every expected item and compares with the ports
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [EW-1:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = table_flat[it.idx*EW +: EW];
        1:       act = EW'(inval_pulse);
        default: act = rd_entry;
      endcase
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  function automatic logic [EW-1:0] mk();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[EW-1:0];
  endfunction

  task automatic push_table(string req);
    for (int i = 0; i < N; i++) sb.push_back('{0, i, mdl[i], req});
  endtask

  task automatic do_cmd(bit w, int idx, bit r, bit shf, int wired,
                        logic [EW-1:0] e, string req);
    @(negedge clk);
    cmd_write = w; cmd_random = r; place_shift = shf;
    cmd_index = 4'(idx); wired_cnt = 5'(wired);
    {new_vpn2, new_asid, new_glob, new_v0, new_d0, new_pfn0,
     new_v1, new_d1, new_pfn1} = e;
    if (r) begin
      if (wired < N) begin
        if (shf) begin
          for (int i = N - 1; i > wired; i--) mdl[i] = mdl[i-1];
          mdl[wired] = e;
        end else begin
          mdl[wired + (int'(bctr) % (N - wired))] = e;
        end
      end
    end else if (w) begin
      mdl[idx] = e;
    end
    @(posedge clk); #1;
    cmd_write = 0; cmd_random = 0;
    push_table(req);
    sb.push_back('{1, 0, EW'(1), "R7"});
  endtask

  task automatic idle_chk();
    @(negedge clk);
    @(posedge clk); #1;
    sb.push_back('{1, 0, EW'(0), "R7"});
  endtask

  task automatic rd_chk(int idx);
    @(posedge clk); #1;
    rd_index = 4'(idx);
    sb.push_back('{2, idx, mdl[idx], "R9"});
  endtask

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    push_table("R1");
    sb.push_back('{1, 0, EW'(0), "R1"});

    // R2: fill every slot by index
    for (int i = 0; i < N; i++) do_cmd(1, i, 0, 1, 0, mk(), "R2");
    idle_chk();
    rd_chk(5); rd_chk(0); rd_chk(15);

    // R3 / R4: shift insert with a middle protected region
    do_cmd(0, 0, 1, 1, 4, mk(), "R3");
    do_cmd(0, 0, 1, 1, 4, mk(), "R4");
    // R3: empty protected region, whole table moves
    do_cmd(0, 0, 1, 1, 0, mk(), "R3");
    // R3: one free slot, nothing moves, top replaced
    do_cmd(0, 0, 1, 1, 15, mk(), "R3");
    rd_chk(4);

    // R5: counter placement at several counter values and regions
    do_cmd(0, 0, 1, 0, 3, mk(), "R5");
    idle_chk();
    do_cmd(0, 0, 1, 0, 3, mk(), "R5");
    do_cmd(0, 0, 1, 0, 0, mk(), "R5");
    idle_chk(); idle_chk();
    do_cmd(0, 0, 1, 0, 11, mk(), "R5");
    do_cmd(0, 0, 1, 0, 15, mk(), "R5");

    // R6: oversized protected region is a no-op in both modes
    do_cmd(0, 0, 1, 1, 16, mk(), "R6");
    do_cmd(0, 0, 1, 0, 16, mk(), "R6");
    do_cmd(0, 0, 1, 1, 31, mk(), "R6");

    // R8: random write wins over simultaneous indexed write
    do_cmd(1, 0, 1, 1, 2, mk(), "R8");
    do_cmd(1, 10, 1, 0, 6, mk(), "R8");
    idle_chk();
    rd_chk(2); rd_chk(9);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule